// File: doc/BRIEF.md
# Cache Snoop Inquiry Initiator

This block is an agent outside the processor that asks the processor's on-chip caches whether they hold a given 32-byte line. A request brings a line address and a flag that says whether a hit line should be invalidated or only downgraded to shared. The initiator first gets the processor off the bus. Normally it raises a hold request and waits for the acknowledge. If the processor has already been pushed off the bus by a back-off condition, it skips the hold handshake.

Once the bus is free, the initiator lets two clocks pass. It then drives the line address and the invalidate flag for one clock, together with a one-clock active-low address strobe. Two clocks after the strobe it samples the processor's active-low hit and hit-modified responses. It reports them with a one-cycle done pulse and two result flags that keep their value until the next inquiry. If the hit was on a modified line, the initiator keeps the bus for a configurable number of clocks so that a write-back can finish. Only then does it release the bus and accept new work.

Top module: `snoopInquirer`

## Requirements
- R1: After reset `busy`, `holdReq`, `addrDrive`, `inqInvalidate` and `done` are 0, `inqAddr` is zero and `eAddrStrobeN` is 1.
- R2: A request is taken at a clock edge where `reqValid` is 1 and `busy` is 0. From the next cycle `busy` is 1. `holdReq` is then 1 if `backoffActive` was 0 at that edge. If `backoffActive` was 1, `holdReq` stays 0 for the whole inquiry.
- R3: In hold mode the strobe stays inactive for as long as neither `holdAck` nor `backoffActive` is sampled high. Either of them counts as the bus grant.
- R4: `eAddrStrobeN` is 0 in exactly one cycle: the third cycle after the edge that sampled the grant, which is the acceptance edge in back-off mode. This leaves two quiet clocks before it.
- R5: In the strobe cycle `addrDrive` is 1 and `inqAddr` carries the accepted line address (byte-address bits 31 to 5). `inqInvalidate` carries the accepted flag: 1 means invalidate on a hit, 0 means mark shared. In every other cycle `addrDrive` and `inqInvalidate` are 0 and `inqAddr` is zero.
- R6: `hitN` and `hitModN` are sampled at the edge that ends the second cycle after the strobe cycle. In the following cycle `done` is 1 for one cycle, with `doneHit` = not `hitN` and `doneHitMod` = not `hitModN`.
- R7: `doneHit` and `doneHitMod` keep their values until the next response capture.
- R8: Without a modified hit, `busy` and `holdReq` are 0 in the `done` cycle. With a modified hit they stay at their inquiry values for `WB_HOLD_CLKS` cycles starting with the `done` cycle, and are 0 after that.
- R9: A request presented while `busy` is 1 is ignored. The address and flag driven in the strobe cycle are those captured at acceptance, and no further inquiry starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Inquiry request |
| reqLineAddr | input | LINE_W | Line address of the request (byte-address bits 31..5) |
| reqInvalidate | input | 1 | 1 = invalidate on hit, 0 = mark shared |
| busy | output | 1 | Inquiry in progress; new requests are ignored |
| holdReq | output | 1 | Bus hold request to the processor |
| holdAck | input | 1 | Hold acknowledge from the processor |
| backoffActive | input | 1 | Processor is held off the bus by back-off |
| inqAddr | output | LINE_W | Inquiry line address, zero when not driven |
| inqInvalidate | output | 1 | Invalidate flag driven with the address |
| addrDrive | output | 1 | Address output enable |
| eAddrStrobeN | output | 1 | Active-low inquiry address strobe |
| hitN | input | 1 | Active-low hit response |
| hitModN | input | 1 | Active-low hit-on-modified response |
| done | output | 1 | One-cycle response-captured pulse |
| doneHit | output | 1 | Captured hit result |
| doneHitMod | output | 1 | Captured modified-hit result |

## Verification
The strobe is due three cycles after the edge that grants the bus. The response is captured on the edge that ends the second cycle after the strobe, so `done` and its flags appear three cycles after the strobe cycle. Bus release follows either in that same cycle or `WB_HOLD_CLKS` cycles later. The bench drives every input at a falling edge and walks the inquiry one falling edge at a time, checking at each edge that every output is low or high as those counts require. Its processor stub changes `hitN` only late in the second cycle after the strobe, so sampling one edge early would read the previous inquiry's stale value.

// File: rtl/snoopPkg.sv
package snoopPkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ACQ    = 3'd1,
    ST_GAP    = 3'd2,
    ST_STROBE = 3'd3,
    ST_RESP   = 3'd4,
    ST_WBHOLD = 3'd5
  } inqState_t;

  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic capture;
  } ctrlStrobes_t;

endpackage

// File: rtl/snoopCtrl.sv
module snoopCtrl
  import snoopPkg::*;
#(
  parameter int GAP_CLKS     = 2,
  parameter int RESP_CLKS    = 2,
  parameter int WB_HOLD_CLKS = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         holdAck,
  input  logic         backoffActive,
  input  logic         hitModN,
  output logic         busy,
  output logic         holdReq,
  output logic         eAddrStrobeN,
  output ctrlStrobes_t cs
);

  localparam int MAX_CNT = (GAP_CLKS > RESP_CLKS)
                         ? ((GAP_CLKS > WB_HOLD_CLKS) ? GAP_CLKS : WB_HOLD_CLKS)
                         : ((RESP_CLKS > WB_HOLD_CLKS) ? RESP_CLKS : WB_HOLD_CLKS);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  inqState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             useHold, useHoldNxt;

  always_comb begin
    stateNxt   = state;
    cntNxt     = cnt;
    useHoldNxt = useHold;
    cs         = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          cs.loadReq = 1'b1;
          if (backoffActive) begin
            useHoldNxt = 1'b0;
            stateNxt   = ST_GAP;
            cntNxt     = CNT_W'(GAP_CLKS - 1);
          end else begin
            useHoldNxt = 1'b1;
            stateNxt   = ST_ACQ;
          end
        end
      end
      ST_ACQ: begin
        if (holdAck || backoffActive) begin
          stateNxt = ST_GAP;
          cntNxt   = CNT_W'(GAP_CLKS - 1);
        end
      end
      ST_GAP: begin
        if (cnt == '0) stateNxt = ST_STROBE;
        else           cntNxt   = cnt - 1'b1;
      end
      ST_STROBE: begin
        cs.driveAddr = 1'b1;
        stateNxt     = ST_RESP;
        cntNxt       = CNT_W'(RESP_CLKS - 1);
      end
      ST_RESP: begin
        if (cnt == '0) begin
          cs.capture = 1'b1;
          if (!hitModN) begin
            stateNxt = ST_WBHOLD;
            cntNxt   = CNT_W'(WB_HOLD_CLKS - 1);
          end else begin
            stateNxt = ST_IDLE;
          end
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_WBHOLD: begin
        if (cnt == '0) stateNxt = ST_IDLE;
        else           cntNxt   = cnt - 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      useHold <= 1'b0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      useHold <= useHoldNxt;
    end
  end

  assign busy         = (state != ST_IDLE);
  assign holdReq      = useHold && (state != ST_IDLE);
  assign eAddrStrobeN = (state != ST_STROBE);

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !eAddrStrobeN |=> eAddrStrobeN);

  // R3
  strobe_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACQ && !holdAck && !backoffActive) |=> eAddrStrobeN);

  // R2
  hold_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdReq |-> busy);

  // R8
  release_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cs.capture && hitModN) |=> !busy);

endmodule

// File: rtl/snoopDatapath.sv
module snoopDatapath
  import snoopPkg::*;
#(
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      cs,
  input  logic [LINE_W-1:0] reqLineAddr,
  input  logic              reqInvalidate,
  input  logic              hitN,
  input  logic              hitModN,
  output logic [LINE_W-1:0] inqAddr,
  output logic              inqInvalidate,
  output logic              addrDrive,
  output logic              done,
  output logic              doneHit,
  output logic              doneHitMod
);

  logic [LINE_W-1:0] lineReg;
  logic              invReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineReg <= '0;
      invReg  <= 1'b0;
    end else if (cs.loadReq) begin
      lineReg <= reqLineAddr;
      invReg  <= reqInvalidate;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done       <= 1'b0;
      doneHit    <= 1'b0;
      doneHitMod <= 1'b0;
    end else begin
      done <= cs.capture;
      if (cs.capture) begin
        doneHit    <= !hitN;
        doneHitMod <= !hitModN;
      end
    end
  end

  assign addrDrive     = cs.driveAddr;
  assign inqAddr       = cs.driveAddr ? lineReg : '0;
  assign inqInvalidate = cs.driveAddr & invReg;

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cs.capture |=> ($stable(doneHit) && $stable(doneHitMod)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/snoopInquirer.sv
module snoopInquirer
  import snoopPkg::*;
#(
  parameter int LINE_W       = 27,
  parameter int GAP_CLKS     = 2,
  parameter int RESP_CLKS    = 2,
  parameter int WB_HOLD_CLKS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LINE_W-1:0] reqLineAddr,
  input  logic              reqInvalidate,
  output logic              busy,
  output logic              holdReq,
  input  logic              holdAck,
  input  logic              backoffActive,
  output logic [LINE_W-1:0] inqAddr,
  output logic              inqInvalidate,
  output logic              addrDrive,
  output logic              eAddrStrobeN,
  input  logic              hitN,
  input  logic              hitModN,
  output logic              done,
  output logic              doneHit,
  output logic              doneHitMod
);

  ctrlStrobes_t cs;

  snoopCtrl #(
    .GAP_CLKS    (GAP_CLKS),
    .RESP_CLKS   (RESP_CLKS),
    .WB_HOLD_CLKS(WB_HOLD_CLKS)
  ) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .holdAck      (holdAck),
    .backoffActive(backoffActive),
    .hitModN      (hitModN),
    .busy         (busy),
    .holdReq      (holdReq),
    .eAddrStrobeN (eAddrStrobeN),
    .cs           (cs)
  );

  snoopDatapath #(
    .LINE_W(LINE_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cs           (cs),
    .reqLineAddr  (reqLineAddr),
    .reqInvalidate(reqInvalidate),
    .hitN         (hitN),
    .hitModN      (hitModN),
    .inqAddr      (inqAddr),
    .inqInvalidate(inqInvalidate),
    .addrDrive    (addrDrive),
    .done         (done),
    .doneHit      (doneHit),
    .doneHitMod   (doneHitMod)
  );

  // Cycles since the strobe, saturating; used only by the checks below.
  localparam int SINCE_MAX = RESP_CLKS + 2;
  localparam int SINCE_W   = $clog2(SINCE_MAX + 1);
  logic [SINCE_W-1:0] sinceStb;

  always_ff @(posedge clk) begin
    if (!rstN)                       sinceStb <= '0;
    else if (!eAddrStrobeN)          sinceStb <= SINCE_W'(1);
    else if (sinceStb != '0 &&
             sinceStb != SINCE_W'(SINCE_MAX)) sinceStb <= sinceStb + 1'b1;
  end

  // R6
  resp_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceStb == SINCE_W'(RESP_CLKS + 1)));

  // R5
  drive_with_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrDrive == !eAddrStrobeN);

  // R9
  no_reload_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(i_dp.lineReg));

  // R4
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eAddrStrobeN) |-> $past(busy, 2));

endmodule

// File: tb/test_snoopInquirer.sv
`timescale 1ns/1ps
module test_snoopInquirer;

  localparam int LW  = 27;
  localparam int WB  = 3;
  localparam real CLK_PER = 20.0;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [LW-1:0] reqLineAddr = '0;
  logic          reqInvalidate = 1'b0;
  logic          busy, holdReq;
  logic          holdAck = 1'b0;
  logic          backoffActive = 1'b0;
  logic [LW-1:0] inqAddr;
  logic          inqInvalidate, addrDrive, eAddrStrobeN;
  logic          hitN = 1'b1;
  logic          hitModN = 1'b1;
  logic          done, doneHit, doneHitMod;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  snoopInquirer #(.LINE_W(LW), .GAP_CLKS(2), .RESP_CLKS(2), .WB_HOLD_CLKS(WB))
    i_snoopInquirer (
      .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLineAddr(reqLineAddr),
      .reqInvalidate(reqInvalidate), .busy(busy), .holdReq(holdReq),
      .holdAck(holdAck), .backoffActive(backoffActive), .inqAddr(inqAddr),
      .inqInvalidate(inqInvalidate), .addrDrive(addrDrive),
      .eAddrStrobeN(eAddrStrobeN), .hitN(hitN), .hitModN(hitModN),
      .done(done), .doneHit(doneHit), .doneHitMod(doneHitMod));

  // Processor stub: line state 0 invalid, 1 clean, 2 modified, indexed by low address bits.
  logic [1:0] tbl [16];
  int         pend = 0;
  logic [3:0] stubIdx;
  logic       stubInv;

  initial for (int i = 0; i < 16; i++) tbl[i] = 2'(i % 3);

  always @(negedge clk) begin
    if (pend == 1) begin
      hitN    = (tbl[stubIdx] == 2'd0);
      hitModN = (tbl[stubIdx] != 2'd2);
      if (tbl[stubIdx] != 2'd0) tbl[stubIdx] = stubInv ? 2'd0 : 2'd1;
    end
    if (pend > 0) pend--;
    if (rstN && !eAddrStrobeN) begin
      pend    = 2;
      stubIdx = inqAddr[3:0];
      stubInv = inqInvalidate;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runInq(input logic [LW-1:0] line, input bit inv, input bit bo,
                        input int ackDly, input bit decoy);
    bit hitE, modE;
    hitE = (tbl[line[3:0]] != 2'd0);
    modE = (tbl[line[3:0]] == 2'd2);
    @(negedge clk);
    reqValid = 1'b1; reqLineAddr = line; reqInvalidate = inv; backoffActive = bo;
    @(negedge clk);
    chk("R2", "busy", busy, 1);
    chk("R2", "holdReq", holdReq, !bo);
    if (decoy) begin
      reqLineAddr = ~line; reqInvalidate = !inv;
    end else reqValid = 1'b0;
    if (!bo) begin
      for (int c = 0; c < ackDly; c++) begin
        chk("R3", "strobe before grant", eAddrStrobeN, 1);
        @(negedge clk);
      end
      chk("R3", "strobe before grant", eAddrStrobeN, 1);
      holdAck = 1'b1;
      @(negedge clk);
    end
    chk("R4", "strobe gap1", eAddrStrobeN, 1);
    @(negedge clk);
    chk("R4", "strobe gap2", eAddrStrobeN, 1);
    chk("R2", "holdReq mid", holdReq, !bo);
    @(negedge clk);
    chk("R4", "strobe", eAddrStrobeN, 0);
    chk("R5", "addrDrive", addrDrive, 1);
    chk("R9", "inqAddr", inqAddr, line);
    chk("R5", "inqInvalidate", inqInvalidate, inv);
    @(negedge clk);
    chk("R4", "strobe after", eAddrStrobeN, 1);
    chk("R5", "addrDrive off", addrDrive, 0);
    chk("R5", "inqAddr off", inqAddr, 0);
    chk("R5", "inqInvalidate off", inqInvalidate, 0);
    chk("R6", "done early1", done, 0);
    @(negedge clk);
    chk("R6", "done early2", done, 0);
    @(negedge clk);
    chk("R6", "done", done, 1);
    chk("R6", "doneHit", doneHit, hitE);
    chk("R6", "doneHitMod", doneHitMod, modE);
    chk("R8", "busy at done", busy, modE);
    chk("R8", "holdReq at done", holdReq, modE && !bo);
    reqValid = 1'b0; holdAck = 1'b0; backoffActive = 1'b0;
    for (int c = 1; c <= WB; c++) begin
      @(negedge clk);
      chk("R8", "busy wb", busy, modE && (c < WB));
      chk("R8", "holdReq wb", holdReq, modE && !bo && (c < WB));
      chk("R9", "no extra strobe", eAddrStrobeN, 1);
      if (c == 1) begin
        chk("R6", "done single", done, 0);
        chk("R7", "doneHit held", doneHit, hitE);
        chk("R7", "doneHitMod held", doneHitMod, modE);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "holdReq", holdReq, 0);
    chk("R1", "strobe", eAddrStrobeN, 1);
    chk("R1", "addrDrive", addrDrive, 0);
    chk("R1", "inqInvalidate", inqInvalidate, 0);
    chk("R1", "inqAddr", inqAddr, 0);
    chk("R1", "done", done, 0);
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 16; i++) begin
        logic [LW-1:0] line;
        line = {23'(p * 40503 + i * 977 + 5), 4'(i)};
        runInq(line, bit'(p[0] ^ i[0]), bit'(p[1]), (i + p) % 4, bit'(i % 5 == 2));
      end
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule